// File: doc/BRIEF.md
# Auto-Increment Burst Memory Engine

This block runs burst read and burst write instructions against a byte-addressed synchronous memory. An instruction begins with a one-cycle start strobe that carries an opcode and a start address A. The nth data byte of the burst then uses address A+n. The address counter wraps from the top of the 12-bit space back to zero. The instruction runs until an end strobe. A start strobe that arrives during an instruction aborts it and begins the new one.

Reading an even address also fetches its odd partner into a one-byte shadow register. The next read in the same burst is that partner, and it returns the shadow copy rather than live memory, so a 16-bit word is read atomically even if memory changes between the two bytes. In a write burst, each incoming byte is stored at its address, and the byte that was there before is returned on the output stream. A restricted register-read opcode works like a plain read but only accepts start addresses below 0x40.

Both data directions use valid/ready. An output byte is held with `out_valid` high and `out_data` unchanged until `out_ready` is seen. The engine issues no further memory access until that handshake. `in_ready` is high only while a write burst is waiting for its next byte. A byte is taken on a cycle where `in_valid` and `in_ready` are both high.

Top module: `burst_mem_engine`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `mem_en` and `addr_err` are all low.
- R2: In a read burst (opcode 2'b00) started at A, the nth byte delivered on the output stream is the memory content at A+n.
- R3: Reading an even address captures the odd partner byte in the same cycle pair. The following byte of the burst returns that captured value, even if memory at the partner address changed in between.
- R4: The shadow copy is discarded when an instruction ends. A new read that starts at the partner address returns the current memory content.
- R5: In a write burst (opcode 2'b01), the nth accepted byte is stored at A+n. The nth output byte is the value held at A+n before that store.
- R6: Every memory write is issued exactly one cycle after a memory read of the same address.
- R7: The burst address wraps from 0xFFF to 0x000.
- R8: A register read (opcode 2'b10) with a start address below 0x40 behaves as a read burst. A register read at or above 0x40, or the reserved opcode 2'b11, gives a one-cycle `addr_err` pulse in the cycle after the start strobe. It returns no data and causes no memory access.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. While a write burst waits with `in_valid` low, no memory access occurs and no output is offered.
- R10: After an end strobe, `out_valid` and `in_ready` are low and no memory access is issued until the next start.
- R11: The memory write enable is raised only during write bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start-of-instruction strobe |
| cmd_op | input | 2 | Opcode: 00 read, 01 write, 10 register read, 11 reserved |
| cmd_addr | input | 12 | Start address (register read uses the low 6 bits) |
| cmd_end | input | 1 | End-of-instruction strobe |
| in_valid | input | 1 | Write byte valid |
| in_ready | output | 1 | Engine ready for a write byte |
| in_data | input | 8 | Write byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts output byte |
| out_data | output | 8 | Read byte or previous contents |
| addr_err | output | 1 | Rejected-start pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read |

## Verification
The assertions check on every cycle that the output byte holds under back-pressure, that each write follows a read of the same address, that writes occur only in write bursts, and that the address counter steps and wraps correctly. They also check that an end strobe silences the memory port and that a rejected start touches nothing. Only the bench scenarios can show the values of the data. These cases need it: the atomic word read while the partner byte is changed underneath, the discarding of the shadow copy across instructions, the old-content return of writes, and the final memory image.

// File: rtl/mae_pkg.sv
package mae_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_REGRD = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_CAP,
    ST_RD_SHD,
    ST_HOLD,
    ST_WR_IN,
    ST_WR_RD,
    ST_WR_WR
  } st_e;
endpackage

// File: rtl/mae_addr_ctr.sv
module mae_addr_ctr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (inc)  q <= q + 1'b1;
  end

  // R2: consecutive bytes use consecutive addresses
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (q == $past(q) + 1'b1));

  // R7: counter wraps at the top of the address space
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (q == '1)) |=> (q == '0));
endmodule

// File: rtl/mae_shadow.sv
module mae_shadow #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] data
);
  logic          valid_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data    <= '0;
    end else if (clear) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr_q  <= ld_addr;
      data    <= ld_data;
    end
  end

  assign hit = valid_q && (addr_q == look_addr);

  // R3: a capture leaves a valid copy tagged with the partner address
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (valid_q && addr_q == $past(ld_addr)));

  // R4: a discard leaves nothing to hit
  a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hit);
endmodule

// File: rtl/mae_out_stage.sv
module mae_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          data_ld,
  input  logic [DW-1:0] data_in,
  input  logic          show,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          fire
);
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else begin
      if (data_ld) out_data <= data_in;
      if (show)      out_valid <= 1'b1;
      else if (fire) out_valid <= 1'b0;
    end
  end

  // R9: an offered byte stays put until it is taken
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  // R9: nothing overwrites a byte still on offer
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fire && !flush) |-> !data_ld);
endmodule

// File: rtl/burst_mem_engine.sv
module burst_mem_engine #(
  parameter int AW     = 12,
  parameter int DW     = 8,
  parameter int REG_AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic          cmd_end,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          addr_err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import mae_pkg::*;

  localparam int HI_W = AW - REG_AW;

  st_e           st_q, st_d;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] partner;
  op_e           op;

  logic start_ok, start_bad, abort;
  logic fire;
  logic mem_en_c, mem_we_c, sel_partner;
  logic ost_ld, ost_show;
  logic [DW-1:0] ost_data;
  logic sh_load, sh_clr_c, sh_hit;
  logic [DW-1:0] sh_data;
  logic in_ready_c, wd_ld;

  assign op      = op_e'(cmd_op);
  assign partner = {addr_q[AW-1:1], 1'b1};

  // start qualification
  always_comb begin
    start_ok = 1'b0;
    if (cmd_start) begin
      unique case (op)
        OP_READ, OP_WRITE: start_ok = 1'b1;
        OP_REGRD:          start_ok = (cmd_addr[AW-1:REG_AW] == {HI_W{1'b0}});
        default:           start_ok = 1'b0;
      endcase
    end
  end
  assign start_bad = cmd_start && !start_ok;
  assign abort     = cmd_start || cmd_end;

  mae_addr_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_val (cmd_addr),
    .inc      (fire && !abort),
    .q        (addr_q)
  );

  mae_shadow #(.AW(AW), .DW(DW)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (abort || sh_clr_c),
    .load      (sh_load),
    .ld_addr   (partner),
    .ld_data   (mem_rdata),
    .look_addr (addr_q),
    .hit       (sh_hit),
    .data      (sh_data)
  );

  mae_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (abort),
    .data_ld   (ost_ld),
    .data_in   (ost_data),
    .show      (ost_show),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .fire      (fire)
  );

  // sequencing
  always_comb begin
    st_d        = st_q;
    mem_en_c    = 1'b0;
    mem_we_c    = 1'b0;
    sel_partner = 1'b0;
    ost_ld      = 1'b0;
    ost_show    = 1'b0;
    ost_data    = mem_rdata;
    sh_load     = 1'b0;
    sh_clr_c    = 1'b0;
    in_ready_c  = 1'b0;
    wd_ld       = 1'b0;
    unique case (st_q)
      ST_IDLE: st_d = ST_IDLE;
      ST_RD_REQ: begin
        sh_clr_c = 1'b1;
        if (sh_hit) begin
          ost_ld   = 1'b1;
          ost_data = sh_data;
          ost_show = 1'b1;
          st_d     = ST_HOLD;
        end else begin
          mem_en_c = 1'b1;
          st_d     = ST_RD_CAP;
        end
      end
      ST_RD_CAP: begin
        ost_ld = 1'b1;
        if (!addr_q[0]) begin
          mem_en_c    = 1'b1;
          sel_partner = 1'b1;
          st_d        = ST_RD_SHD;
        end else begin
          ost_show = 1'b1;
          st_d     = ST_HOLD;
        end
      end
      ST_RD_SHD: begin
        sh_load  = 1'b1;
        ost_show = 1'b1;
        st_d     = ST_HOLD;
      end
      ST_HOLD: begin
        if (fire) st_d = wr_q ? ST_WR_IN : ST_RD_REQ;
      end
      ST_WR_IN: begin
        in_ready_c = 1'b1;
        if (in_valid) begin
          wd_ld = 1'b1;
          st_d  = ST_WR_RD;
        end
      end
      ST_WR_RD: begin
        mem_en_c = 1'b1;
        st_d     = ST_WR_WR;
      end
      ST_WR_WR: begin
        mem_en_c = 1'b1;
        mem_we_c = 1'b1;
        ost_ld   = 1'b1;
        ost_show = 1'b1;
        st_d     = ST_HOLD;
      end
      default: st_d = ST_IDLE;
    endcase
    if (start_ok)   st_d = (op == OP_WRITE) ? ST_WR_IN : ST_RD_REQ;
    else if (abort) st_d = ST_IDLE;
  end

  assign mem_en    = mem_en_c && !abort;
  assign mem_we    = mem_we_c && !abort;
  assign mem_addr  = sel_partner ? partner : addr_q;
  assign mem_wdata = wdata_q;
  assign in_ready  = in_ready_c && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      addr_err <= 1'b0;
    end else begin
      st_q     <= st_d;
      addr_err <= start_bad;
      if (start_ok) wr_q <= (op == OP_WRITE);
      if (wd_ld && !abort) wdata_q <= in_data;
    end
  end

  // R6: each store is preceded one cycle earlier by a fetch of the same byte
  a_r6_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && ($past(mem_addr) == mem_addr)));

  // R11: stores happen only inside write bursts
  a_r11_write_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && wr_q));

  // R8: a rejected start leaves the engine silent
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!out_valid && !mem_en && !in_ready));

  // R10: the end strobe quiets both streams and the memory port
  a_r10_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && !cmd_start) |=> (!out_valid && !mem_en && !in_ready));

  // R9: a byte is never requested while one is still on offer
  a_r9_in_vs_out: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
endmodule

// File: tb/sim_burst_mem_engine.sv
module sim_burst_mem_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [11:0] cmd_addr = '0;
  logic        cmd_end = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        addr_err;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  always #10 clk = ~clk;

  burst_mem_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_end(cmd_end), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .addr_err(addr_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model, one-cycle read latency
  logic [7:0]  mem [4096];
  logic        poke_en = 1'b0;
  logic [11:0] poke_a = '0;
  logic [7:0]  poke_d = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 37 + 5);
      mem_rdata <= '0;
    end else begin
      if (poke_en) mem[poke_a] <= poke_d;
      if (mem_en) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr];
      end
    end
  end

  int    checks = 0;
  int    errors = 0;
  int    pops = 0;
  int    cyc = 0;
  string cur_req = "R2";
  logic  wr_mode = 1'b0;
  logic [7:0] exp_q[$];
  logic  prev_rd = 1'b0;
  logic [11:0] prev_addr = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(cur_req, "unexpected byte", {24'h0, out_data}, 32'hFFFF);
        else chk(cur_req, "stream byte", {24'h0, out_data}, {24'h0, exp_q.pop_front()});
        pops++;
      end
      if (mem_en && mem_we) begin
        chk("R6", "fetch before store", {31'h0, prev_rd && (prev_addr == mem_addr)}, 1);
        chk("R11", "store in write mode", {31'h0, wr_mode}, 1);
      end
      prev_rd   = mem_en && !mem_we;
      prev_addr = mem_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      report();
    end
  end

  function automatic logic [7:0] wval(logic [11:0] a, int i);
    return a[7:0] ^ 8'(i * 29 + 90);
  endfunction

  task automatic pulse_start(logic [1:0] op, logic [11:0] a);
    @(posedge clk); #1;
    cmd_start = 1'b1; cmd_op = op; cmd_addr = a;
    @(posedge clk); #1;
    cmd_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(posedge clk); #1;
    cmd_end = 1'b1;
    @(posedge clk); #1;
    cmd_end = 1'b0;
  endtask

  task automatic poke(logic [11:0] a, logic [7:0] d);
    @(posedge clk); #1;
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(posedge clk); #1;
    poke_en = 1'b0;
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!out_valid);
  endtask

  task automatic read_burst(logic [1:0] op, logic [11:0] a, int n, string req);
    int target;
    cur_req = req;
    target = pops + n;
    for (int i = 0; i < n; i++) exp_q.push_back(mem[12'(a + 12'(i))]);
    out_ready = 1'b1;
    pulse_start(op, a);
    wait (pops == target);
    @(posedge clk); #1;
    out_ready = 1'b0;
    pulse_end();
    chk(req, "all bytes seen", exp_q.size(), 0);
  endtask

  task automatic write_burst(logic [11:0] a, int n, string req);
    int target;
    cur_req = req;
    target = pops + n;
    for (int i = 0; i < n; i++) exp_q.push_back(mem[12'(a + 12'(i))]);
    wr_mode = 1'b1;
    out_ready = 1'b1;
    pulse_start(2'b01, a);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = wval(a, i);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
    wait (pops == target);
    @(posedge clk); #1;
    out_ready = 1'b0;
    pulse_end();
    wr_mode = 1'b0;
    chk(req, "old bytes seen", exp_q.size(), 0);
    for (int i = 0; i < n; i++)
      chk(req, "stored byte", {24'h0, mem[12'(a + 12'(i))]}, {24'h0, wval(a, i)});
  endtask

  initial begin
    logic [7:0] old, d0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", {31'h0, out_valid}, 0);
    chk("R1", "in_ready in reset", {31'h0, in_ready}, 0);
    chk("R1", "mem_en in reset", {31'h0, mem_en}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "addr_err after reset", {31'h0, addr_err}, 0);
    chk("R1", "out_valid after reset", {31'h0, out_valid}, 0);

    // R2: plain bursts from even and odd starts
    read_burst(2'b00, 12'h010, 5, "R2");
    read_burst(2'b00, 12'h123, 3, "R2");

    // R3 and R9: atomic word under back-pressure while the partner changes
    cur_req = "R3";
    old = mem[12'h101];
    exp_q.push_back(mem[12'h100]);
    exp_q.push_back(old);
    out_ready = 1'b0;
    pulse_start(2'b00, 12'h100);
    wait_valid();
    d0 = out_data;
    repeat (3) @(negedge clk);
    chk("R9", "valid held", {31'h0, out_valid}, 1);
    chk("R9", "data held", {24'h0, out_data}, {24'h0, d0});
    poke(12'h101, ~old);
    chk("R3", "memory really changed", {24'h0, mem[12'h101]}, {24'h0, ~old});
    begin
      int target;
      target = pops + 2;
      @(posedge clk); #1;
      out_ready = 1'b1;
      wait (pops == target);
      @(posedge clk); #1;
      out_ready = 1'b0;
    end
    pulse_end();

    // R4: shadow copy dropped at instruction end
    out_ready = 1'b0;
    pulse_start(2'b00, 12'h200);
    wait_valid();
    pulse_end();
    poke(12'h201, 8'hC3);
    read_burst(2'b00, 12'h201, 1, "R4");

    // R5: write burst returns previous contents, then read back
    write_burst(12'h080, 4, "R5");
    read_burst(2'b00, 12'h080, 4, "R5");

    // R7: wrap in both directions
    read_burst(2'b00, 12'hFFE, 4, "R7");
    write_burst(12'hFFF, 2, "R7");

    // R8: register read accepted and rejected
    read_burst(2'b10, 12'h03E, 3, "R8");
    pulse_start(2'b10, 12'h040);
    @(negedge clk);
    chk("R8", "reject pulse", {31'h0, addr_err}, 1);
    repeat (4) begin
      @(negedge clk);
      chk("R8", "quiet after reject", {29'h0, addr_err, mem_en, out_valid}, 0);
    end
    pulse_start(2'b11, 12'h000);
    @(negedge clk);
    chk("R8", "reserved opcode pulse", {31'h0, addr_err}, 1);
    @(negedge clk);
    chk("R8", "pulse is one cycle", {30'h0, addr_err, mem_en}, 0);

    // R9: write stall with no input byte
    wr_mode = 1'b1;
    pulse_start(2'b01, 12'h400);
    repeat (4) begin
      @(negedge clk);
      chk("R9", "stall quiet", {29'h0, in_ready, mem_en, out_valid}, 3'b100);
    end
    pulse_end();
    wr_mode = 1'b0;

    // R10: end during read hold and during write wait
    old = mem[12'h300];
    pulse_start(2'b00, 12'h208);
    wait_valid();
    pulse_end();
    @(negedge clk);
    chk("R10", "valid dropped", {31'h0, out_valid}, 0);
    repeat (4) begin
      @(negedge clk);
      chk("R10", "no access after end", {31'h0, mem_en}, 0);
    end
    wr_mode = 1'b1;
    pulse_start(2'b01, 12'h300);
    @(negedge clk);
    chk("R10", "write waiting", {31'h0, in_ready}, 1);
    pulse_end();
    wr_mode = 1'b0;
    @(negedge clk);
    chk("R10", "in_ready dropped", {31'h0, in_ready}, 0);
    chk("R10", "memory untouched", {24'h0, mem[12'h300]}, {24'h0, old});

    repeat (3) @(negedge clk);
    report();
  end
endmodule